// File: doc/BRIEF.md
# Address Table Search and Insert Engine

This engine serves a forwarding table held in an external single-port-read memory. A command names a key. The key is either a 48-bit station address qualified by a 12-bit VLAN id, or a VLAN id alone. The engine walks the table from index 0 upward through a synchronous read port. It compares each returned entry against the key and classifies the entry as free, displaceable or neither.

A find command reports the lowest matching index, or a not-found flag. An insert command picks a target slot by strict priority: an existing match comes first, then the lowest free slot, then the lowest displaceable (ageable) unicast slot. It writes the supplied entry there verbatim through a write port. If no slot qualifies, it raises a full flag and writes nothing.

A single pass gathers the free and ageable candidates, so any command costs at most one sweep plus the write. Commands are issued with a start pulse. Completion is a one-cycle done pulse that carries the index and the two flags.

Top module: `addr_scan_engine`

## Requirements
- R1: During and after reset, with no command issued, `done_o`, `wr_en_o`, `rd_en_o` and `busy_o` are low.
- R2: An address key matches an entry when entry bits [61:60] are 1 or 3, bits [59:48] equal `key_vid_i` and bits [47:0] equal `key_mac_i`. The first transmitted address byte is `key_mac_i[47:40]`, and byte n sits at [47-8n:40-8n].
- R3: A VLAN key (`key_vlan_i`=1) matches an entry only when bits [61:60] are 2 and bits [59:48] equal `key_vid_i`. The address bits are ignored.
- R4: A find (`op_insert_i`=0) completes with `res_idx_o` set to the lowest matching index and `not_found_o`=0. With no match it completes with `not_found_o`=1 and `res_idx_o`=0. A find never writes.
- R5: The read port presents indices 0,1,2,... one per cycle, and data returns the cycle after the index. The scan stops at the first match. `done_o` rises k+2 cycles after the accepting edge for a decision at index k, and DEPTH+1 cycles after it when the whole table is swept.
- R6: An insert whose key matches an entry writes to the lowest matching index.
- R7: An insert with no match writes to the lowest-index free entry (bits [61:60]=0).
- R8: An insert with no match and no free entry writes to the lowest-index ageable entry. An ageable entry has type 1 or 3, bit 40 clear, and bits [63:62] neither 0 (persistent) nor 2 (vendor-prefix).
- R9: An insert with no match, no free and no ageable entry completes with `full_o`=1, `res_idx_o`=0 and no write.
- R10: `done_o` is high for exactly one cycle. A write occurs in that same cycle, with `wr_idx_o`=`res_idx_o`, and `wr_data_o` equal to the command's entry bit for bit, including the port number [67:66], the blocked flag [65] and the secure flag [64].
- R11: A start pulse while `busy_o` is high is ignored, and the running command completes with its own result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Command start pulse, accepted while idle |
| op_insert_i | input | 1 | 1 = insert, 0 = find |
| key_vlan_i | input | 1 | 1 = VLAN key, 0 = address key |
| key_vid_i | input | 12 | Key VLAN id |
| key_mac_i | input | 48 | Key station address, first byte in [47:40] |
| new_entry_i | input | 68 | Entry to store on insert |
| rd_en_o | output | 1 | Table read request |
| rd_idx_o | output | IDX_W | Table read index |
| rd_data_i | input | 68 | Table read data, one cycle after the request |
| wr_en_o | output | 1 | Table write strobe |
| wr_idx_o | output | IDX_W | Table write index |
| wr_data_o | output | 68 | Table write data |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| res_idx_o | output | IDX_W | Result index |
| not_found_o | output | 1 | Find found no match |
| full_o | output | 1 | Insert found no usable slot |

## Verification
A corrupted candidate register or scan counter shows up as a wrong `res_idx_o`, or as a write landing in a slot other than the one the priority rules select. It appears on the done pulse of the very next command whose decision depends on it. A wrong compare-stage index or a stop condition that fires late moves the done pulse away from the k+2 or DEPTH+1 cycle budget, so the bench measures latency on every command. Tables are built from a mix of every entry class across many patterns, and each outcome is compared against an arithmetic model of the priority rules.

// File: rtl/addr_scan_pkg.sv
package addr_scan_pkg;
  localparam int ENTRY_W = 68;
  localparam int VID_W   = 12;
  localparam int MAC_W   = 48;

  typedef enum logic [1:0] {
    KIND_FREE  = 2'd0,
    KIND_ADDR  = 2'd1,
    KIND_VLAN  = 2'd2,
    KIND_VADDR = 2'd3
  } ent_kind_e;

  typedef enum logic [1:0] {
    UC_PERSIST = 2'd0,
    UC_FRESH   = 2'd1,
    UC_VENDOR  = 2'd2,
    UC_AGED    = 2'd3
  } uc_kind_e;

  typedef struct packed {
    logic hit;
    logic free;
    logic ageable;
  } slot_class_t;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_SCAN = 1'b1
  } seq_state_e;
endpackage

// File: rtl/entry_classifier.sv
module entry_classifier
  import addr_scan_pkg::*;
(
  input  logic [ENTRY_W-1:0] entry_i,
  input  logic               key_vlan_i,
  input  logic [VID_W-1:0]   key_vid_i,
  input  logic [MAC_W-1:0]   key_mac_i,
  output slot_class_t        cls_o
);
  ent_kind_e  kind;
  uc_kind_e   uck;
  logic       is_addr;
  logic       vid_eq;
  logic       unused_hi;

  assign kind      = ent_kind_e'(entry_i[61:60]);
  assign uck       = uc_kind_e'(entry_i[63:62]);
  assign unused_hi = ^entry_i[67:64];

  always_comb begin
    is_addr = (kind == KIND_ADDR) || (kind == KIND_VADDR);
    vid_eq  = (entry_i[59:48] == key_vid_i);
    if (key_vlan_i) begin
      cls_o.hit = (kind == KIND_VLAN) && vid_eq;
    end else begin
      cls_o.hit = is_addr && vid_eq && (entry_i[47:0] == key_mac_i);
    end
    cls_o.free    = (kind == KIND_FREE);
    cls_o.ageable = is_addr && !entry_i[40] &&
                    (uck != UC_PERSIST) && (uck != UC_VENDOR);
  end
endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
  import addr_scan_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept_i,
  input  logic             stop_i,
  output logic             rd_en_o,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic             cmp_vld_o,
  output logic [IDX_W-1:0] cmp_idx_o,
  output logic             cmp_last_o,
  output logic             busy_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] iss_q, iss_d, cidx_q, cidx_d;
  logic             act_q, act_d, cvld_q, cvld_d;

  always_comb begin
    state_d = state_q;
    iss_d   = iss_q;
    act_d   = act_q;
    cvld_d  = 1'b0;
    cidx_d  = cidx_q;
    if (state_q == SEQ_IDLE) begin
      if (accept_i) begin
        state_d = SEQ_SCAN;
        iss_d   = '0;
        act_d   = 1'b1;
      end
    end else if (stop_i) begin
      state_d = SEQ_IDLE;
      act_d   = 1'b0;
    end else begin
      cvld_d = act_q;
      if (act_q) begin
        cidx_d = iss_q;
        if (iss_q == LAST) act_d = 1'b0;
        else               iss_d = iss_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      iss_q   <= '0;
      act_q   <= 1'b0;
      cvld_q  <= 1'b0;
      cidx_q  <= '0;
    end else begin
      state_q <= state_d;
      iss_q   <= iss_d;
      act_q   <= act_d;
      cvld_q  <= cvld_d;
      cidx_q  <= cidx_d;
    end
  end

  assign rd_en_o    = (state_q == SEQ_SCAN) && act_q;
  assign rd_idx_o   = iss_q;
  assign cmp_vld_o  = cvld_q;
  assign cmp_idx_o  = cidx_q;
  assign cmp_last_o = cvld_q && (cidx_q == LAST);
  assign busy_o     = (state_q == SEQ_SCAN);
endmodule

// File: rtl/slot_tracker.sv
module slot_tracker #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             vld_i,
  input  logic             cand_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             any_o,
  output logic [IDX_W-1:0] pick_o
);
  logic             seen_q, seen_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             cap;

  always_comb begin
    cap    = vld_i && cand_i && !seen_q;
    seen_d = seen_q;
    idx_d  = idx_q;
    if (clr_i) begin
      seen_d = 1'b0;
    end else if (cap) begin
      seen_d = 1'b1;
      idx_d  = idx_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      seen_q <= seen_d;
      idx_q  <= idx_d;
    end
  end

  assign any_o  = seen_q || (vld_i && cand_i);
  assign pick_o = seen_q ? idx_q : idx_i;
endmodule

// File: rtl/addr_scan_engine.sv
module addr_scan_engine
  import addr_scan_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               op_insert_i,
  input  logic               key_vlan_i,
  input  logic [11:0]        key_vid_i,
  input  logic [47:0]        key_mac_i,
  input  logic [67:0]        new_entry_i,
  output logic               rd_en_o,
  output logic [IDX_W-1:0]   rd_idx_o,
  input  logic [67:0]        rd_data_i,
  output logic               wr_en_o,
  output logic [IDX_W-1:0]   wr_idx_o,
  output logic [67:0]        wr_data_o,
  output logic               busy_o,
  output logic               done_o,
  output logic [IDX_W-1:0]   res_idx_o,
  output logic               not_found_o,
  output logic               full_o
);
  logic               accept, stop;
  logic               cmp_vld, cmp_last;
  logic [IDX_W-1:0]   cmp_idx;
  slot_class_t        cls;
  logic               free_any, age_any;
  logic [IDX_W-1:0]   free_pick, age_pick;

  logic               ins_q, kvl_q;
  logic [VID_W-1:0]   kvid_q;
  logic [MAC_W-1:0]   kmac_q;
  logic [ENTRY_W-1:0] ent_q;

  logic               done_q, we_q, nf_q, full_q;
  logic [IDX_W-1:0]   ridx_q;
  logic               we_d, nf_d, full_d;
  logic [IDX_W-1:0]   ridx_d;

  assign accept = start_i && !busy_o;

  scan_sequencer #(.DEPTH(DEPTH)) u_seq (
    .clk(clk), .rst_n(rst_n), .accept_i(accept), .stop_i(stop),
    .rd_en_o(rd_en_o), .rd_idx_o(rd_idx_o),
    .cmp_vld_o(cmp_vld), .cmp_idx_o(cmp_idx), .cmp_last_o(cmp_last),
    .busy_o(busy_o)
  );

  entry_classifier u_cls (
    .entry_i(rd_data_i), .key_vlan_i(kvl_q), .key_vid_i(kvid_q),
    .key_mac_i(kmac_q), .cls_o(cls)
  );

  slot_tracker #(.IDX_W(IDX_W)) u_free (
    .clk(clk), .rst_n(rst_n), .clr_i(accept), .vld_i(cmp_vld),
    .cand_i(cls.free), .idx_i(cmp_idx), .any_o(free_any), .pick_o(free_pick)
  );

  slot_tracker #(.IDX_W(IDX_W)) u_age (
    .clk(clk), .rst_n(rst_n), .clr_i(accept), .vld_i(cmp_vld),
    .cand_i(cls.ageable), .idx_i(cmp_idx), .any_o(age_any), .pick_o(age_pick)
  );

  // command capture, clock-enabled by acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ins_q  <= 1'b0;
      kvl_q  <= 1'b0;
      kvid_q <= '0;
      kmac_q <= '0;
      ent_q  <= '0;
    end else if (accept) begin
      ins_q  <= op_insert_i;
      kvl_q  <= key_vlan_i;
      kvid_q <= key_vid_i;
      kmac_q <= key_mac_i;
      ent_q  <= new_entry_i;
    end
  end

  // decision: match beats free beats ageable
  always_comb begin
    stop   = cmp_vld && (cls.hit || cmp_last);
    we_d   = 1'b0;
    nf_d   = 1'b0;
    full_d = 1'b0;
    ridx_d = '0;
    if (cmp_vld && cls.hit) begin
      ridx_d = cmp_idx;
      we_d   = ins_q;
    end else if (!ins_q) begin
      nf_d = 1'b1;
    end else if (free_any) begin
      ridx_d = free_pick;
      we_d   = 1'b1;
    end else if (age_any) begin
      ridx_d = age_pick;
      we_d   = 1'b1;
    end else begin
      full_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      we_q   <= 1'b0;
    end else begin
      done_q <= stop;
      we_q   <= stop && we_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ridx_q <= '0;
      nf_q   <= 1'b0;
      full_q <= 1'b0;
    end else if (stop) begin
      ridx_q <= ridx_d;
      nf_q   <= nf_d;
      full_q <= full_d;
    end
  end

  assign done_o      = done_q;
  assign wr_en_o     = we_q;
  assign wr_idx_o    = ridx_q;
  assign wr_data_o   = ent_q;
  assign res_idx_o   = ridx_q;
  assign not_found_o = nf_q;
  assign full_o      = full_q;
endmodule

// File: rtl/addr_scan_engine_chk.sv
module addr_scan_engine_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             not_found_o,
  input logic             full_o,
  input logic             wr_en_o,
  input logic             rd_en_o,
  input logic [IDX_W-1:0] rd_idx_o
);
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_quiet_in_reset: assert (!done_o && !wr_en_o && !rd_en_o && !busy_o)
        else $error("R1 outputs active during reset");
    end
  end

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r9_write_needs_slot: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> (done_o && !full_o && !not_found_o));

  a_r4_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !(not_found_o && full_o));

  a_r5_sequential_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_o && $past(rd_en_o)) |-> (rd_idx_o == IDX_W'($past(rd_idx_o) + 1'b1)));

  a_r5_read_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_o |-> busy_o);

  a_r11_start_takes_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);
endmodule

bind addr_scan_engine addr_scan_engine_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .not_found_o(not_found_o), .full_o(full_o),
  .wr_en_o(wr_en_o), .rd_en_o(rd_en_o), .rd_idx_o(rd_idx_o)
);

// File: tb/addr_scan_engine_bench.sv
module addr_scan_engine_bench;
  localparam int DEPTH = 16;
  localparam int IDX_W = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n;
  logic start_i, op_insert_i, key_vlan_i;
  logic [11:0] key_vid_i;
  logic [47:0] key_mac_i;
  logic [67:0] new_entry_i;
  logic rd_en_o, wr_en_o, busy_o, done_o, not_found_o, full_o;
  logic [IDX_W-1:0] rd_idx_o, wr_idx_o, res_idx_o;
  logic [67:0] rd_data_i, wr_data_o;

  always #2 clk = ~clk;

  addr_scan_engine #(.DEPTH(DEPTH)) u_addr_scan_engine (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_insert_i(op_insert_i),
    .key_vlan_i(key_vlan_i), .key_vid_i(key_vid_i), .key_mac_i(key_mac_i),
    .new_entry_i(new_entry_i), .rd_en_o(rd_en_o), .rd_idx_o(rd_idx_o),
    .rd_data_i(rd_data_i), .wr_en_o(wr_en_o), .wr_idx_o(wr_idx_o),
    .wr_data_o(wr_data_o), .busy_o(busy_o), .done_o(done_o),
    .res_idx_o(res_idx_o), .not_found_o(not_found_o), .full_o(full_o)
  );

  // table storage model
  logic [67:0] mem [DEPTH];
  logic        bk_we;
  logic [IDX_W-1:0] bk_idx;
  logic [67:0] bk_data;

  always @(posedge clk) begin
    if (wr_en_o) mem[wr_idx_o] <= wr_data_o;
    else if (bk_we) mem[bk_idx] <= bk_data;
    if (rd_en_o) rd_data_i <= mem[rd_idx_o];
  end

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [67:0] act, input logic [67:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic poke(input int idx, input logic [67:0] d);
    @(negedge clk);
    bk_we = 1'b1; bk_idx = IDX_W'(idx); bk_data = d;
    @(negedge clk);
    bk_we = 1'b0;
  endtask

  function automatic logic [47:0] mac_of(input int i);
    return {8'h02, 8'h11, 8'hA0, 8'hB0, 8'hC0, 8'(i)};
  endfunction

  // fields: [67:66] port, [65] blocked, [64] secure, [63:62] ucast kind,
  // [61:60] type, [59:48] vid, [47:0] mac
  function automatic logic [67:0] mk(input int cat, input int i);
    logic [11:0] v;
    logic [47:0] m;
    v = 12'(i % 3);
    m = mac_of(i);
    case (cat)
      0: return {4'h0, 2'd1, 2'd0, v, m};
      1: return {4'h0, 2'd0, 2'd1, v, m};
      2: return {4'h0, 2'd1, 2'd1, v, m};
      3: return {4'h0, 2'd3, 2'd3, v, m};
      4: return {4'h0, 2'd2, 2'd1, v, m};
      5: return {4'h0, 2'd1, 2'd1, v, m | 48'h0100_0000_0000};
      6: return {4'h0, 2'd0, 2'd2, v, 48'h0};
      default: return {4'h0, 2'd3, 2'd1, v, m};
    endcase
  endfunction

  function automatic bit is_match(input logic [67:0] e, input bit kv, input logic [11:0] vid, input logic [47:0] mac);
    if (kv) return (e[61:60] == 2'd2) && (e[59:48] == vid);
    return ((e[61:60] == 2'd1) || (e[61:60] == 2'd3)) && (e[59:48] == vid) && (e[47:0] == mac);
  endfunction

  // expected result per rules R4..R9
  task automatic model(input bit ins, input bit kv, input logic [11:0] vid, input logic [47:0] mac,
                       output int idx, output bit nf, output bit full, output int lat, output string tag);
    int hit = -1, fr = -1, ag = -1;
    for (int i = 0; i < DEPTH; i++) begin
      if (hit < 0 && is_match(mem[i], kv, vid, mac)) hit = i;
      if (fr < 0 && mem[i][61:60] == 2'd0) fr = i;
      if (ag < 0 && (mem[i][61:60] == 2'd1 || mem[i][61:60] == 2'd3) && !mem[i][40]
          && mem[i][63:62] != 2'd0 && mem[i][63:62] != 2'd2) ag = i;
    end
    nf = 0; full = 0; idx = 0; lat = DEPTH + 1;
    if (hit >= 0) begin
      idx = hit; lat = hit + 2; tag = ins ? "R6" : "R4";
    end else if (!ins) begin
      nf = 1; tag = "R4";
    end else if (fr >= 0) begin
      idx = fr; tag = "R7";
    end else if (ag >= 0) begin
      idx = ag; tag = "R8";
    end else begin
      full = 1; tag = "R9";
    end
  endtask

  int  r_lat;
  bit  r_we;
  logic [IDX_W-1:0] r_idx, r_widx;
  bit  r_nf, r_full;
  logic [67:0] r_wdata;

  task automatic run(input bit ins, input bit kv, input logic [11:0] vid, input logic [47:0] mac,
                     input logic [67:0] ent, input int restart_at);
    @(negedge clk);
    start_i = 1'b1; op_insert_i = ins; key_vlan_i = kv; key_vid_i = vid;
    key_mac_i = mac; new_entry_i = ent;
    @(negedge clk);
    start_i = 1'b0;
    r_lat = 0;
    while (!done_o && r_lat < 100) begin
      if (r_lat == restart_at) begin
        start_i = 1'b1; op_insert_i = ~ins; key_vlan_i = ~kv; key_mac_i = ~mac;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
      r_lat++;
    end
    start_i = 1'b0;
    r_we = wr_en_o; r_idx = res_idx_o; r_widx = wr_idx_o; r_nf = not_found_o;
    r_full = full_o; r_wdata = wr_data_o;
    @(negedge clk);
    chk(!done_o, "R10 done one cycle", 68'(done_o), 68'd0);
  endtask

  task automatic check_cmd(input bit ins, input bit kv, input logic [11:0] vid, input logic [47:0] mac,
                           input logic [67:0] ent, input int restart_at);
    int eidx, elat; bit enf, efull; string tag;
    model(ins, kv, vid, mac, eidx, enf, efull, elat, tag);
    run(ins, kv, vid, mac, ent, restart_at);
    chk(r_idx == IDX_W'(eidx) && r_nf == enf && r_full == efull,
        {tag, " result idx/nf/full"}, {r_idx, r_nf, r_full}, {IDX_W'(eidx), enf, efull});
    chk(r_lat == elat, "R5 latency", 68'(r_lat), 68'(elat));
    chk(r_we == (ins && !efull), {tag, " R4 R9 write strobe"}, 68'(r_we), 68'(ins && !efull));
    if (ins && !efull) begin
      chk(r_widx == IDX_W'(eidx) && r_wdata == ent, "R10 write idx/data", {r_widx, r_wdata}, {IDX_W'(eidx), ent});
      chk(mem[eidx] == ent, {tag, " stored entry"}, mem[eidx], ent);
    end
  endtask

  initial begin
    int ci;
    bit kv, ins;
    int j;
    logic [11:0] kvid;
    logic [67:0] ent;
    int l1[4] = '{1, 4, 5, 6};
    int l2[6] = '{1, 2, 4, 5, 6, 7};
    rst_n = 1'b0; start_i = 1'b0; op_insert_i = 1'b0; key_vlan_i = 1'b0;
    key_vid_i = '0; key_mac_i = '0; new_entry_i = '0; bk_we = 1'b0;
    bk_idx = '0; bk_data = '0;
    repeat (3) @(negedge clk);
    chk(!done_o && !wr_en_o && !rd_en_o && !busy_o, "R1 reset outputs",
        {done_o, wr_en_o, rd_en_o, busy_o}, 68'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!done_o && !wr_en_o && !rd_en_o && !busy_o, "R1 idle after reset",
        {done_o, wr_en_o, rd_en_o, busy_o}, 68'd0);

    // R2 byte order: first byte in [47:40]
    for (int i = 0; i < DEPTH; i++) poke(i, mk(0, i));
    poke(5, {4'h0, 2'd0, 2'd1, 12'd9, 48'h1A2B3C4D5E6F});
    check_cmd(0, 0, 12'd9, 48'h1A2B3C4D5E6F, '0, -1);
    chk(r_idx == 5 && !r_nf, "R2 address match", {r_idx, r_nf}, {IDX_W'(5), 1'b0});
    check_cmd(0, 0, 12'd9, 48'h6F5E4D3C2B1A, '0, -1);
    chk(r_nf, "R2 reversed bytes miss", 68'(r_nf), 68'd1);
    check_cmd(0, 0, 12'd8, 48'h1A2B3C4D5E6F, '0, -1);
    chk(r_nf, "R2 vid mismatch miss", 68'(r_nf), 68'd1);

    // R3 vlan key ignores address entries with same vid
    poke(2, {4'h0, 2'd0, 2'd1, 12'd9, 48'h0});
    poke(7, {4'h0, 2'd0, 2'd2, 12'd9, 48'hFFFF});
    check_cmd(0, 1, 12'd9, 48'h0, '0, -1);
    chk(r_idx == 7, "R3 vlan match", 68'(r_idx), 68'd7);

    // R11 restart mid-scan ignored
    check_cmd(0, 1, 12'd9, 48'h0, '0, 3);
    chk(r_idx == 7 && !r_nf, "R11 restart ignored", {r_idx, r_nf}, {IDX_W'(7), 1'b0});

    // sweep of mixed tables
    for (int t = 0; t < 60; t++) begin
      for (int i = 0; i < DEPTH; i++) begin
        case (t % 4)
          1: ci = l1[(i + t) % 4];
          2: ci = l2[(i * 3 + t) % 6];
          default: ci = (i * 5 + t * 3) % 8;
        endcase
        if (t % 4 == 3 && i < t % 16) ci = 1;
        poke(i, mk(ci, i));
      end
      j = (t * 7 + 3) % DEPTH;
      kv = (t % 5 == 0);
      kvid = (t % 3 == 0) ? 12'd7 : 12'(j % 3);
      ins = (t % 3 != 0);
      ent = {2'(t), 1'(t >> 2), 1'b1, 2'd3, kv ? 2'd3 : 2'd1, kvid, mac_of(j)};
      check_cmd(ins, kv, kvid, mac_of(j), ent, -1);
    end

    // full table, then displace ageable at every position
    for (int k = 0; k < DEPTH; k++) begin
      for (int i = 0; i < DEPTH; i++) poke(i, mk((i == k) ? 7 : l1[i % 4], i));
      check_cmd(1, 0, 12'd5, 48'hABCDEF012345, {4'hE, 2'd1, 2'd1, 12'd5, 48'hABCDEF012345}, -1);
      chk(r_idx == IDX_W'(k) && !r_full, "R8 ageable position", 68'(r_idx), 68'(k));
    end
    for (int i = 0; i < DEPTH; i++) poke(i, mk(l1[i % 4], i));
    check_cmd(1, 0, 12'd5, 48'hABCDEF012345, {4'hE, 2'd1, 2'd1, 12'd5, 48'hABCDEF012345}, -1);
    chk(r_full && !r_we, "R9 full no write", {r_full, r_we}, 2'b10);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule